// File: doc/BRIEF.md
# Byte-Serial Counter Command Interface

This block is the host-facing register unit for one up/down counter channel. The count value is 24 bits by default. The host reaches it through two byte-wide ports. The data port moves multi-byte values one byte per access, steered by a byte pointer that steps after every access. Writes build up the preset value, and reads drain a snapshot of the count called the output latch.

The control port takes command bytes. Bits [6:5] of a command choose where it lands. One target is an action decoder whose low bits fire strobes and transfers. The other three targets are configuration registers: count mode, input control and index control. A status byte built from the counting core's flags is held on its own output.

The counting itself happens in a separate core. That core receives the preset value, the clear and load strobes and the configuration fields, and it returns its live count and status bits.

Top module: `ctr_host_regs`

## Requirements
- R1: After reset, the following are all zero: the preset, the prescaler, the output latch, the read data, the status byte, the byte pointer, every strobe and every configuration field. This gives pulse/direction mode, normal count mode, inputs disabled, index load enabled (active-low bit at 0) and negative index polarity.
- R2: Command bits [6:5] choose the target: 00 action, 01 count mode, 10 input control, 11 index control. A command changes only its own target, and command bit 7 is ignored.
- R3: A count-mode command stores bits [2:1] as the count mode (0 normal, 1 range-limit, 2 non-recycle, 3 modulo-N) and bits [4:3] as the quadrature setting (0 pulse/direction, 1 x1, 2 x2, 3 x4). Both appear on the outputs one cycle later.
- R4: An input-control command stores bit 0 as the A/B input enable and bit 1 as the active-low index-load enable. An index-control command stores bit 0 as synchronous mode and bit 1 as polarity (1 = positive).
- R5: Each data-port write stores its byte in the preset lane picked by the byte pointer, least significant lane first. Every data access, read or write, advances the pointer by one, and the pointer wraps from lane 2 back to lane 0.
- R6: A data-port read places the output-latch lane picked by the byte pointer on `rdata` in the next cycle, least significant lane first.
- R7: Action bit 0 returns the byte pointer to lane 0. A data access in the same cycle is served at the old pointer, and the pointer still ends at lane 0.
- R8: Action bits [2:1] fire a one-cycle strobe in the following cycle: 01 clears the counter, 10 clears the borrow/carry/compare/sign flags, 11 clears the error flag.
- R9: Action bits [4:3] select a transfer: 01 pulses the counter load strobe for one cycle; 10 captures the core's count into the output latch; 11 copies the preset's low byte into the prescaler. A same-cycle data read returns the latch value held before the capture.
- R10: The status byte follows the core one cycle later. Bit 0 is borrow, bit 1 carry, bit 4 error and bit 5 direction (1 = up); all other bits are zero.
- R11: Several action bits in one command all take effect together. For example, a pointer reset with a latch capture, or a counter clear with a load.
- R12: Action commands leave the three configuration registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| ctrl_wr | input | 1 | Control-port command strobe |
| wdata | input | 8 | Byte written on either port |
| rdata | output | 8 | Registered data-port read byte |
| flag_byte | output | 8 | Registered status byte |
| core_count | input | 24 | Live count from the counting core |
| core_borrow | input | 1 | Borrow toggle from the core |
| core_carry | input | 1 | Carry toggle from the core |
| core_err | input | 1 | Noise error flag from the core |
| core_up | input | 1 | Count direction from the core, 1 = up |
| preset_val | output | 24 | Preset register contents |
| cnt_load | output | 1 | Load preset into counter strobe |
| cnt_clear | output | 1 | Clear counter strobe |
| flags_clear | output | 1 | Clear borrow/carry/compare/sign strobe |
| err_clear | output | 1 | Clear error flag strobe |
| prescaler | output | 8 | Filter clock prescaler value |
| count_mode | output | 2 | Count mode field |
| quad_mode | output | 2 | Quadrature setting field |
| ab_enable | output | 1 | A/B input enable |
| idx_load_n | output | 1 | Active-low enable for loading the preset on index |
| idx_sync | output | 1 | Synchronous index mode |
| idx_positive | output | 1 | Index polarity, 1 = positive |

## Verification
The two functions that can fall in one cycle are a control-port action and a data-port read. A pointer reset can arrive together with a latch capture while the read strobe is also high. The bench provokes this in the middle of a read sequence, with the pointer at lane 1 and the core count changed since the last capture. It expects the old lane-1 byte of the old snapshot on `rdata`. It then expects the next read to return lane 0 of the new snapshot, which shows that the pointer reset and the capture both took effect.

// File: rtl/ctr_host_pkg.sv
package ctr_host_pkg;

  typedef enum logic [1:0] {
    TGT_ACTION = 2'b00,
    TGT_MODE   = 2'b01,
    TGT_IOCTL  = 2'b10,
    TGT_INDEX  = 2'b11
  } target_e;

  typedef struct packed {
    logic ptr_rst;
    logic clr_cnt;
    logic clr_flags;
    logic clr_err;
    logic load;
    logic latch;
    logic psc;
  } action_t;

  localparam int FLAG_BORROW = 0;
  localparam int FLAG_CARRY  = 1;
  localparam int FLAG_ERROR  = 4;
  localparam int FLAG_UP     = 5;

endpackage

// File: rtl/ctr_cmd_decode.sv
module ctr_cmd_decode
  import ctr_host_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [6:0] cmd,
  output action_t    act,
  output logic       we_mode,
  output logic       we_ioctl,
  output logic       we_index
);
  target_e tgt;
  logic    is_act;

  always_comb begin
    tgt      = target_e'(cmd[6:5]);
    is_act   = cmd_valid && (tgt == TGT_ACTION);
    we_mode  = cmd_valid && (tgt == TGT_MODE);
    we_ioctl = cmd_valid && (tgt == TGT_IOCTL);
    we_index = cmd_valid && (tgt == TGT_INDEX);

    act           = '0;
    act.ptr_rst   = is_act && cmd[0];
    act.clr_cnt   = is_act && (cmd[2:1] == 2'b01);
    act.clr_flags = is_act && (cmd[2:1] == 2'b10);
    act.clr_err   = is_act && (cmd[2:1] == 2'b11);
    act.load      = is_act && (cmd[4:3] == 2'b01);
    act.latch     = is_act && (cmd[4:3] == 2'b10);
    act.psc       = is_act && (cmd[4:3] == 2'b11);
  end
endmodule

// File: rtl/ctr_byte_ptr.sv
module ctr_byte_ptr #(
  parameter int LANES = 3,
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             clear,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LANES - 1);

  always_ff @(posedge clk) begin
    if (rst || clear)      ptr <= '0;
    else if (advance)      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear && ptr == LAST) |=> ptr == '0);
endmodule

// File: rtl/ctr_cfg_reg.sv
module ctr_cfg_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/ctr_host_regs.sv
module ctr_host_regs
  import ctr_host_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 3,
  localparam int CNT_W = BYTE_W * LANES,
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  input  logic [7:0]        wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [7:0]        flag_byte,
  input  logic [CNT_W-1:0]  core_count,
  input  logic              core_borrow,
  input  logic              core_carry,
  input  logic              core_err,
  input  logic              core_up,
  output logic [CNT_W-1:0]  preset_val,
  output logic              cnt_load,
  output logic              cnt_clear,
  output logic              flags_clear,
  output logic              err_clear,
  output logic [BYTE_W-1:0] prescaler,
  output logic [1:0]        count_mode,
  output logic [1:0]        quad_mode,
  output logic              ab_enable,
  output logic              idx_load_n,
  output logic              idx_sync,
  output logic              idx_positive
);
  action_t          act;
  logic             we_mode, we_ioctl, we_index;
  logic [PTR_W-1:0] ptr;
  logic [3:0]       mode_q;
  logic [1:0]       io_q, idx_q;
  logic [CNT_W-1:0] latch_vec;
  logic             unused_top_bit;

  assign unused_top_bit = wdata[7];

  ctr_cmd_decode u_dec (
    .cmd_valid (ctrl_wr),
    .cmd       (wdata[6:0]),
    .act       (act),
    .we_mode   (we_mode),
    .we_ioctl  (we_ioctl),
    .we_index  (we_index)
  );

  ctr_byte_ptr #(.LANES(LANES)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .advance (data_wr || data_rd),
    .clear   (act.ptr_rst),
    .ptr     (ptr)
  );

  ctr_cfg_reg #(.W(4)) u_mode (
    .clk (clk), .rst (rst), .we (we_mode), .din (wdata[4:1]), .q (mode_q)
  );
  ctr_cfg_reg #(.W(2)) u_ioctl (
    .clk (clk), .rst (rst), .we (we_ioctl), .din (wdata[1:0]), .q (io_q)
  );
  ctr_cfg_reg #(.W(2)) u_index (
    .clk (clk), .rst (rst), .we (we_index), .din (wdata[1:0]), .q (idx_q)
  );

  assign count_mode   = mode_q[1:0];
  assign quad_mode    = mode_q[3:2];
  assign ab_enable    = io_q[0];
  assign idx_load_n   = io_q[1];
  assign idx_sync     = idx_q[0];
  assign idx_positive = idx_q[1];

  // Per-lane preset and output latch storage
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] pre_q, lat_q;

    always_ff @(posedge clk) begin
      if (rst) pre_q <= '0;
      else if (data_wr && ptr == PTR_W'(g)) pre_q <= wdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) lat_q <= '0;
      else if (act.latch) lat_q <= core_count[g*BYTE_W +: BYTE_W];
    end

    assign preset_val[g*BYTE_W +: BYTE_W] = pre_q;
    assign latch_vec[g*BYTE_W +: BYTE_W]  = lat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      prescaler   <= '0;
      flag_byte   <= '0;
      cnt_load    <= 1'b0;
      cnt_clear   <= 1'b0;
      flags_clear <= 1'b0;
      err_clear   <= 1'b0;
    end else begin
      if (data_rd)  rdata     <= latch_vec[ptr*BYTE_W +: BYTE_W];
      if (act.psc)  prescaler <= preset_val[BYTE_W-1:0];
      flag_byte              <= '0;
      flag_byte[FLAG_BORROW] <= core_borrow;
      flag_byte[FLAG_CARRY]  <= core_carry;
      flag_byte[FLAG_ERROR]  <= core_err;
      flag_byte[FLAG_UP]     <= core_up;
      cnt_load    <= act.load;
      cnt_clear   <= act.clr_cnt;
      flags_clear <= act.clr_flags;
      err_clear   <= act.clr_err;
    end
  end

  assert_ptr_reset_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[6:5] == 2'b00 && wdata[0]) |=> ptr == '0);

  assert_psc_copy_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[6:5] == 2'b00 && wdata[4:3] == 2'b11)
      |=> prescaler == $past(preset_val[BYTE_W-1:0]));

  assert_latch_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[6:5] == 2'b00 && wdata[4:3] == 2'b10)
      |=> latch_vec == $past(core_count));

  assert_load_cause_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_load |-> $past(ctrl_wr));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cnt_clear, flags_clear, err_clear}));
endmodule

// File: tb/sim_ctr_host_regs.sv
module sim_ctr_host_regs;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        data_wr = 0, data_rd = 0, ctrl_wr = 0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, flag_byte, prescaler;
  logic [23:0] core_count = '0, preset_val;
  logic        core_borrow = 0, core_carry = 0, core_err = 0, core_up = 0;
  logic        cnt_load, cnt_clear, flags_clear, err_clear;
  logic [1:0]  count_mode, quad_mode;
  logic        ab_enable, idx_load_n, idx_sync, idx_positive;

  ctr_host_regs u0 (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_rd(data_rd),
    .ctrl_wr(ctrl_wr), .wdata(wdata), .rdata(rdata), .flag_byte(flag_byte),
    .core_count(core_count), .core_borrow(core_borrow),
    .core_carry(core_carry), .core_err(core_err), .core_up(core_up),
    .preset_val(preset_val), .cnt_load(cnt_load), .cnt_clear(cnt_clear),
    .flags_clear(flags_clear), .err_clear(err_clear), .prescaler(prescaler),
    .count_mode(count_mode), .quad_mode(quad_mode), .ab_enable(ab_enable),
    .idx_load_n(idx_load_n), .idx_sync(idx_sync), .idx_positive(idx_positive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Observation selectors
  localparam int S_RDATA = 0, S_FLAG = 1, S_PRESET = 2, S_PSC = 3,
                 S_MODE = 4, S_IO = 5, S_IDX = 6, S_STROBE = 7;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    int          req;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      S_RDATA:  return {24'd0, rdata};
      S_FLAG:   return {24'd0, flag_byte};
      S_PRESET: return {8'd0, preset_val};
      S_PSC:    return {24'd0, prescaler};
      S_MODE:   return {28'd0, quad_mode, count_mode};
      S_IO:     return {30'd0, idx_load_n, ab_enable};
      S_IDX:    return {30'd0, idx_positive, idx_sync};
      default:  return {28'd0, err_clear, flags_clear, cnt_clear, cnt_load};
    endcase
  endfunction

  // Monitor: pops items that fall due and compares them
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      logic [31:0] got;
      it  = sb.pop_front();
      got = observe(it.sel);
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel,
                 got, it.exp);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 5000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
    end
  end

  task automatic push(int sel, logic [31:0] e, int req, int ahead = 1);
    exp_t it;
    it.due = cyc + ahead;
    it.sel = sel;
    it.exp = e;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic step(bit dw, bit dr, bit cw, logic [7:0] wd);
    data_wr = dw; data_rd = dr; ctrl_wr = cw; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    data_wr = 0; data_rd = 0; ctrl_wr = 0; wdata = '0;
  endtask

  task automatic idle();
    step(0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every observed field
    for (int s = 0; s < 8; s++) push(s, 32'h0, 1);
    idle();

    // R3: count mode and quadrature fields, several patterns
    push(S_MODE, 32'h6, 3);                 // cnt 2, quad 1
    step(0, 0, 1, 8'h20 | (2 << 1) | (1 << 3));
    push(S_MODE, 32'hB, 3);                 // cnt 3, quad 2
    step(0, 0, 1, 8'h20 | (3 << 1) | (2 << 3));
    // R2: bit 7 ignored, command still reaches the mode register only
    push(S_MODE, 32'hE, 2);
    push(S_IO,   32'h0, 2);
    push(S_IDX,  32'h0, 2);
    step(0, 0, 1, 8'hA0 | (2 << 1) | (3 << 3));

    // R4: input control then index control
    push(S_IO,   32'h3, 4);
    push(S_MODE, 32'hE, 2);
    step(0, 0, 1, 8'h43);
    push(S_IDX,  32'h2, 4);
    push(S_IO,   32'h3, 2);
    step(0, 0, 1, 8'h62);

    // R5: preset written least significant lane first, then wrap
    step(0, 0, 1, 8'h01);
    step(1, 0, 0, 8'h11);
    step(1, 0, 0, 8'h22);
    push(S_PRESET, 32'h332211, 5);
    step(1, 0, 0, 8'h33);
    push(S_PRESET, 32'h332244, 5);
    step(1, 0, 0, 8'h44);

    // R9: preset low byte to prescaler, no strobe fired
    push(S_PSC, 32'h44, 9);
    push(S_STROBE, 32'h0, 9);
    step(0, 0, 1, 8'h18);

    // R6, R11: pointer reset with latch capture, then read lanes in order
    core_count = 24'hABCDEF;
    step(0, 0, 1, 8'h11);
    core_count = 24'h000000;
    push(S_RDATA, 32'hEF, 6); step(0, 1, 0, 8'h00);
    push(S_RDATA, 32'hCD, 6); step(0, 1, 0, 8'h00);
    push(S_RDATA, 32'hAB, 6); step(0, 1, 0, 8'h00);
    push(S_RDATA, 32'hEF, 5); step(0, 1, 0, 8'h00);  // wrap on reads

    // R7, R9: read at lane 1 in same cycle as pointer reset + capture
    core_count = 24'h123456;
    push(S_RDATA, 32'hCD, 7);
    step(0, 1, 1, 8'h11);
    push(S_RDATA, 32'h56, 7);
    step(0, 1, 0, 8'h00);

    // R8: each clear strobe for one cycle
    push(S_STROBE, 32'h2, 8); push(S_STROBE, 32'h0, 8, 2);
    step(0, 0, 1, 8'h02);
    idle();
    push(S_STROBE, 32'h4, 8); push(S_STROBE, 32'h0, 8, 2);
    step(0, 0, 1, 8'h04);
    idle();
    push(S_STROBE, 32'h8, 8); push(S_STROBE, 32'h0, 8, 2);
    step(0, 0, 1, 8'h06);
    idle();
    // R9: load strobe alone
    push(S_STROBE, 32'h1, 9);
    step(0, 0, 1, 8'h08);
    // R11: counter clear combined with load
    push(S_STROBE, 32'h3, 11);
    step(0, 0, 1, 8'h0A);

    // R12: action commands leave configuration untouched
    push(S_MODE, 32'hE, 12, 2);
    push(S_IO,   32'h3, 12, 2);
    push(S_IDX,  32'h2, 12, 2);
    step(0, 0, 1, 8'h1F);
    idle();

    // R10: status byte bit positions
    core_borrow = 1; core_up = 1;
    push(S_FLAG, 32'h21, 10);
    idle();
    core_borrow = 0; core_up = 0; core_carry = 1; core_err = 1;
    push(S_FLAG, 32'h12, 10);
    idle();
    core_carry = 0; core_err = 0;
    push(S_FLAG, 32'h00, 10);
    idle();

    repeat (3) idle();
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks, fails);
    $finish;
  end
endmodule